// File: doc/BRIEF.md
# Memory-Side Atomic Operation Unit

This unit sits in front of one shared cache slice and carries out 64-bit read-modify-write operations for any requester. There is no separate opcode field. A requester issues an ordinary load or store, and the top three address bits say which atomic operation to perform. The bits below them pick the word. Because every operation on the slice goes through this one unit, all requesters share a single point at which atomic updates are ordered.

Loads return the value the word held before the operation and may also update it: clear, increment, decrement, and increment or decrement against a bound. Stores merge the supplied data into memory: add, add with a coherence hint on zero, twin write, OR, XOR, unsigned maximum and signed maximum. The backing word array is modelled inside the block as a single-ported memory. Each row of that memory holds an even/odd pair of words, so one read fetches both the addressed word and its partner. Every operation takes a fixed read cycle followed by a modify-and-write cycle. The unit accepts one request per two cycles, so a following request always sees the previous result.

Top module: `atom_unit`

## Requirements
- R1: The byte address splits as opcode = req_addr[ADDR_W-1:ADDR_W-3], word index = req_addr[ADDR_W-4:3], and bits [2:0] are ignored. The partner word of index i is the word at index i with bit 0 inverted.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 for the next cycle. rsp_valid is 1 for exactly one cycle, starting at the second rising edge after acceptance.
- R3: Load opcode 0, and the unused load opcodes 6 and 7, return the word and leave memory unchanged.
- R4: Store opcode 0 writes req_wdata to the word. Every store response carries rsp_rdata = 0.
- R5: Load opcode 1 (clear) returns the old word and writes zero.
- R6: Load opcode 2 returns the old word and writes word+1. Load opcode 3 returns the old word and writes word-1. Both wrap modulo 2^64.
- R7: Load opcodes 4 and 5 are bounded increment and bounded decrement, using the partner word as the bound. If the word equals the bound, memory is unchanged and the response is 0x8000_0000_0000_0000. Otherwise they behave like opcodes 2 and 3.
- R8: Store opcodes 1 (add) and 2 (add with coherence hint on zero) both write word+req_wdata, modulo 2^64.
- R9: Store opcode 3 (twin) writes req_wdata to both the word and its partner only if the two were equal before the operation. Otherwise memory is unchanged.
- R10: Store opcode 4 writes word OR req_wdata. Store opcode 5 writes word XOR req_wdata.
- R11: Store opcode 6 writes the unsigned maximum of the word and req_wdata. Store opcode 7 writes the signed (two's complement) maximum.
- R12: A request offered while the previous one is in flight is held off until the write-back is done, and then observes the updated word. The memory never performs a read and a write in the same cycle.
- R13: After reset, req_ready is 1, rsp_valid is 0 and every word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_is_store | input | 1 | 1 = store-type operation, 0 = load-type |
| req_addr | input | ADDR_W | Byte address: opcode, word index, ignored offset |
| req_wdata | input | 64 | Store operand |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 64 | Old word, failure marker, or zero for stores |

## Verification
The bench builds the unit with ADDR_W = 10. That gives 16 words in 8 pair rows, small enough for a behavioural model that mirrors the whole array and for a final sweep that reads every word back. At this size the bench reaches both lanes of a row, partner-bound failures in both directions, wrap-around at the top and bottom of the 64-bit range, and held-off back-to-back requests. It also covers non-zero byte offsets and the unused load opcodes, which must leave the array untouched.

// File: rtl/atom_pkg.sv
package atom_pkg;
    localparam int WORD_W = 64;
    localparam int OP_W   = 3;

    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [2*WORD_W-1:0] pair_t;

    // load-type operation codes (upper address bits)
    typedef enum logic [OP_W-1:0] {
        LD_PLAIN   = 3'd0,
        LD_CLEAR   = 3'd1,
        LD_INC     = 3'd2,
        LD_DEC     = 3'd3,
        LD_INC_BND = 3'd4,
        LD_DEC_BND = 3'd5,
        LD_SPARE6  = 3'd6,
        LD_SPARE7  = 3'd7
    } ld_op_e;

    // store-type operation codes (upper address bits)
    typedef enum logic [OP_W-1:0] {
        ST_PLAIN   = 3'd0,
        ST_ADD     = 3'd1,
        ST_ADD_COZ = 3'd2,
        ST_TWIN    = 3'd3,
        ST_OR      = 3'd4,
        ST_XOR     = 3'd5,
        ST_UMAX    = 3'd6,
        ST_SMAX    = 3'd7
    } st_op_e;

    localparam word_t BOUND_FAIL = {1'b1, {(WORD_W-1){1'b0}}};
endpackage

// File: rtl/atom_addr_split.sv
module atom_addr_split
    import atom_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:3]        addr_hi,
    output logic [OP_W-1:0]          op,
    output logic [ADDR_W-OP_W-5:0]   row,
    output logic                     lane
);
    localparam int IDX_W = ADDR_W - OP_W - 3;

    logic [IDX_W-1:0] idx;

    always_comb begin
        op   = addr_hi[ADDR_W-1 -: OP_W];
        idx  = addr_hi[IDX_W+2:3];
        row  = idx[IDX_W-1:1];
        lane = idx[0];
    end
endmodule

// File: rtl/atom_rmw_alu.sv
module atom_rmw_alu
    import atom_pkg::*;
(
    input  logic            is_store,
    input  logic [OP_W-1:0] op,
    input  logic            lane,
    input  word_t           wdata,
    input  pair_t           pair_in,
    output pair_t           pair_out,
    output logic            wr_need,
    output word_t           rsp
);
    word_t cur, nbr, cur_d, nbr_d;

    always_comb begin
        cur   = lane ? pair_in[2*WORD_W-1:WORD_W] : pair_in[WORD_W-1:0];
        nbr   = lane ? pair_in[WORD_W-1:0]        : pair_in[2*WORD_W-1:WORD_W];
        cur_d = cur;
        nbr_d = nbr;
        rsp   = '0;

        if (!is_store) begin
            rsp = cur;
            unique case (ld_op_e'(op))
                LD_CLEAR: cur_d = '0;
                LD_INC:   cur_d = cur + word_t'(1);
                LD_DEC:   cur_d = cur - word_t'(1);
                LD_INC_BND: begin
                    if (cur == nbr) rsp = BOUND_FAIL;
                    else            cur_d = cur + word_t'(1);
                end
                LD_DEC_BND: begin
                    if (cur == nbr) rsp = BOUND_FAIL;
                    else            cur_d = cur - word_t'(1);
                end
                default: cur_d = cur;
            endcase
        end else begin
            unique case (st_op_e'(op))
                ST_PLAIN:   cur_d = wdata;
                ST_ADD,
                ST_ADD_COZ: cur_d = cur + wdata;
                ST_TWIN: begin
                    if (cur == nbr) begin
                        cur_d = wdata;
                        nbr_d = wdata;
                    end
                end
                ST_OR:   cur_d = cur | wdata;
                ST_XOR:  cur_d = cur ^ wdata;
                ST_UMAX: cur_d = (wdata > cur) ? wdata : cur;
                ST_SMAX: cur_d = ($signed(wdata) > $signed(cur)) ? wdata : cur;
                default: cur_d = cur;
            endcase
        end

        pair_out = lane ? {cur_d, nbr_d} : {nbr_d, cur_d};
        wr_need  = (pair_out != pair_in);
    end
endmodule

// File: rtl/atom_pair_ram.sv
module atom_pair_ram
    import atom_pkg::*;
#(
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  pair_t            wr_data,
    output pair_t            rd_data
);
    localparam int ROWS = 1 << ROW_W;

    pair_t mem_q [ROWS];
    pair_t rd_q;

    // one port: the unit never asks for a read and a write together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
            rd_q <= '0;
        end else if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end else if (rd_en) begin
            rd_q <= mem_q[rd_row];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/atom_unit.sv
module atom_unit
    import atom_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);
    localparam int IDX_W = ADDR_W - OP_W - 3;
    localparam int ROW_W = IDX_W - 1;

    typedef struct packed {
        logic             busy;
        logic             is_store;
        logic [OP_W-1:0]  op;
        logic             lane;
        logic [ROW_W-1:0] row;
        word_t            wdata;
        logic             rsp_valid;
        word_t            rsp_data;
    } state_t;

    state_t s_q, s_d;

    logic [OP_W-1:0]  dec_op;
    logic [ROW_W-1:0] dec_row;
    logic             dec_lane;
    logic             accept;
    logic             mem_rd, mem_wr;
    pair_t            mem_rdata, alu_pair;
    logic             alu_wr;
    word_t            alu_rsp;

    atom_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr_hi (req_addr[ADDR_W-1:3]),
        .op      (dec_op),
        .row     (dec_row),
        .lane    (dec_lane)
    );

    atom_pair_ram #(.ROW_W(ROW_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (mem_rd),
        .rd_row  (dec_row),
        .wr_en   (mem_wr),
        .wr_row  (s_q.row),
        .wr_data (alu_pair),
        .rd_data (mem_rdata)
    );

    atom_rmw_alu u_alu (
        .is_store (s_q.is_store),
        .op       (s_q.op),
        .lane     (s_q.lane),
        .wdata    (s_q.wdata),
        .pair_in  (mem_rdata),
        .pair_out (alu_pair),
        .wr_need  (alu_wr),
        .rsp      (alu_rsp)
    );

    assign req_ready = !s_q.busy;
    assign accept    = req_valid && req_ready;
    assign mem_rd    = accept;
    assign mem_wr    = s_q.busy && alu_wr;
    assign rsp_valid = s_q.rsp_valid;
    assign rsp_rdata = s_q.rsp_data;

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        if (accept) begin
            s_d.busy     = 1'b1;
            s_d.is_store = req_is_store;
            s_d.op       = dec_op;
            s_d.lane     = dec_lane;
            s_d.row      = dec_row;
            s_d.wdata    = req_wdata;
        end
        if (s_q.busy) begin
            s_d.busy      = 1'b0;
            s_d.rsp_valid = 1'b1;
            s_d.rsp_data  = alu_rsp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/atom_unit_chk.sv
module atom_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_is_store,
    input logic        rsp_valid,
    input logic [63:0] rsp_rdata,
    input logic        mem_rd,
    input logic        mem_wr
);
    logic st_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      st_q <= 1'b0;
        else if (req_valid && req_ready) st_q <= req_is_store;
    end

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r2_rsp_second_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 rsp_valid);

    a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_free_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    a_r4_store_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && st_q) |-> (rsp_rdata == 64'd0));

    a_r12_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind atom_unit atom_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_is_store (req_is_store),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr)
);

// File: tb/atom_unit_test.sv
module atom_unit_test;
    localparam int AW = 10;
    localparam int IW = AW - 6;
    localparam int NW = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   want_rsp = 1'b0;
    bit   done = 1'b0;
    logic [63:0] mdl [NW];

    always #10 clk = ~clk;

    atom_unit #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison of the response strobe against the model's timeline (R2)
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) check("R2 strobe", {63'd0, rsp_valid}, {63'd0, want_rsp});
    end

    // behavioural reference: returns the expected response and updates the model
    function automatic logic [63:0] model_op(bit st, int code, int idx, logic [63:0] wd);
        int p = idx ^ 1;
        logic [63:0] c = mdl[idx];
        logic [63:0] n = mdl[p];
        logic [63:0] r = 64'd0;
        if (!st) begin
            r = c;
            case (code)
                1: mdl[idx] = 64'd0;
                2: mdl[idx] = c + 64'd1;
                3: mdl[idx] = c - 64'd1;
                4: if (c == n) r = 64'h8000_0000_0000_0000; else mdl[idx] = c + 64'd1;
                5: if (c == n) r = 64'h8000_0000_0000_0000; else mdl[idx] = c - 64'd1;
                default: ;
            endcase
        end else begin
            case (code)
                0: mdl[idx] = wd;
                1, 2: mdl[idx] = c + wd;
                3: if (c == n) begin mdl[idx] = wd; mdl[p] = wd; end
                4: mdl[idx] = c | wd;
                5: mdl[idx] = c ^ wd;
                6: if (wd > c) mdl[idx] = wd;
                7: if ($signed(wd) > $signed(c)) mdl[idx] = wd;
                default: ;
            endcase
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] mk_addr(int code, int idx, int off);
        return {code[2:0], idx[IW-1:0], off[2:0]};
    endfunction

    task automatic op(bit st, int code, int idx, logic [63:0] wd, string req, int off = 0);
        logic [63:0] exp;
        @(negedge clk);
        req_valid    = 1'b1;
        req_is_store = st;
        req_addr     = mk_addr(code, idx, off);
        req_wdata    = wd;
        exp = model_op(st, code, idx, wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 ready low", {63'd0, req_ready}, 64'd0);
        want_rsp = 1'b1;
        @(negedge clk);
        check(req, {63'd0, rsp_valid}, 64'd1);
        check(req, rsp_rdata, exp);
        want_rsp = 1'b0;
    endtask

    initial begin
        logic [63:0] e1, e2;
        for (int i = 0; i < NW; i++) mdl[i] = 64'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 ready", {63'd0, req_ready}, 64'd1);
        check("R13 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        op(0, 0, 0, 0, "R13 word0 zero");
        op(0, 0, 9, 0, "R13 word9 zero");

        // plain accesses, byte offset ignored (R1, R3, R4)
        op(1, 0, 2, 64'h1234_5678_9abc_def0, "R4 plain store");
        op(0, 0, 2, 0, "R3 plain load");
        op(0, 0, 2, 0, "R1 offset ignored", 5);
        op(0, 6, 2, 0, "R3 spare op6");
        op(0, 7, 2, 0, "R3 spare op7");
        op(0, 0, 2, 0, "R3 unchanged after spare ops");
        op(0, 0, 3, 0, "R1 partner untouched");

        // clear (R5)
        op(0, 1, 2, 0, "R5 clear returns old");
        op(0, 0, 2, 0, "R5 cleared word");

        // increment / decrement with wrap (R6)
        op(1, 0, 6, 64'hFFFF_FFFF_FFFF_FFFF, "R4 store");
        op(0, 2, 6, 0, "R6 inc at top");
        op(0, 0, 6, 0, "R6 inc wrapped");
        op(0, 3, 6, 0, "R6 dec at zero");
        op(0, 3, 6, 0, "R6 dec again");
        op(0, 0, 6, 0, "R6 dec result");

        // bounded ops against partner (R7)
        op(1, 0, 4, 64'd10, "R4 store");
        op(1, 0, 5, 64'd12, "R4 store");
        op(0, 4, 4, 0, "R7 binc below bound");
        op(0, 4, 4, 0, "R7 binc reaches bound");
        op(0, 4, 4, 0, "R7 binc at bound fails");
        op(0, 0, 4, 0, "R7 unchanged after fail");
        op(0, 5, 5, 0, "R7 bdec at bound fails");
        op(1, 0, 4, 64'd3, "R4 store");
        op(0, 5, 5, 0, "R7 bdec below");
        op(0, 0, 5, 0, "R7 bdec result");

        // add flavours (R8)
        op(1, 1, 8, 64'd7, "R8 add");
        op(1, 2, 8, 64'hFFFF_FFFF_FFFF_FFFA, "R8 add coz wrap");
        op(0, 0, 8, 0, "R8 sum");

        // twin (R9)
        op(1, 3, 10, 64'hAAAA, "R9 twin equal");
        op(0, 0, 10, 0, "R9 twin word");
        op(0, 0, 11, 0, "R9 twin partner");
        op(1, 1, 11, 64'd1, "R8 add");
        op(1, 3, 10, 64'hBBBB, "R9 twin unequal");
        op(0, 0, 10, 0, "R9 unequal word kept");
        op(0, 0, 11, 0, "R9 unequal partner kept");

        // logic ops (R10)
        op(1, 0, 12, 64'hF0F0, "R4 store");
        op(1, 4, 12, 64'h0F00, "R10 or");
        op(1, 5, 12, 64'hFF0F, "R10 xor");
        op(0, 0, 12, 0, "R10 result");

        // max ops (R11)
        op(1, 0, 13, 64'd100, "R4 store");
        op(1, 6, 13, 64'd50, "R11 umax smaller");
        op(1, 6, 13, 64'hFFFF_FFFF_FFFF_FFF0, "R11 umax larger");
        op(0, 0, 13, 0, "R11 umax result");
        op(1, 0, 14, 64'hFFFF_FFFF_FFFF_FFF0, "R4 store");
        op(1, 7, 14, 64'd5, "R11 smax positive wins");
        op(1, 7, 14, 64'hFFFF_FFFF_FFFF_FFFE, "R11 smax negative loses");
        op(0, 0, 14, 0, "R11 smax result");

        // back-to-back: second request held, then sees first's write (R12)
        @(negedge clk);
        req_valid = 1'b1; req_is_store = 1'b1;
        req_addr = mk_addr(0, 15, 0); req_wdata = 64'd77;
        e1 = model_op(1, 0, 15, 64'd77);
        @(posedge clk);
        @(negedge clk);
        check("R12 held off", {63'd0, req_ready}, 64'd0);
        req_is_store = 1'b0; req_addr = mk_addr(2, 15, 0); req_wdata = 64'd0;
        e2 = model_op(0, 2, 15, 64'd0);
        want_rsp = 1'b1;
        @(negedge clk);
        check("R12 first rsp", rsp_rdata, e1);
        check("R12 ready after wb", {63'd0, req_ready}, 64'd1);
        want_rsp = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        want_rsp = 1'b1;
        @(negedge clk);
        check("R12 second sees first", rsp_rdata, e2);
        want_rsp = 1'b0;

        // full sweep against the model (R1, R12)
        for (int i = 0; i < NW; i++) op(0, 0, i, 0, "R12 final sweep");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule